// File: doc/BRIEF.md
# IDE Strobe Timing Sequencer

This block produces the chip-select, register-address and read/write strobe waveforms for one access at a time to a set of IDE register windows. A host-side requester presents an access request with a 12-bit local offset and a direction flag. The sequencer then runs a fixed-length select window, counted in bus clock cycles. It raises the read or write strobe part way through that window and drops it on the same edge as the select. In the cycle after the select ends it gives a one-cycle completion pulse.

A small speed register holds a 3-bit timing code, and each code maps to a pair of values: the select length and the strobe delay. Offset bit 6 gives a slow path that ignores the speed register and always uses the longest command-safe timing. The register-window count is a parameter: the base configuration has four selects, and the extended configuration adds two more.

Top module: `ide_strobe_seq`

## Requirements
- R1: After reset the speed register reads 0x1F. A write stores write-data bits 7..5 as the timing code, and a read returns the code in bits 7..5 with bits 4..0 always 1.
- R2: Timing codes 0..7 give (select cycles, strobe delay) of (7,2), (9,3), (11,4), (5,1), (5,2), (5,3), (15,4) and (5,1) respectively.
- R3: The strobe is high from select cycle number "delay" (counting from 0) through the last select cycle, and it falls on the same edge as the select. `ide_rd` is used when `acc_wr`=0 and `ide_wr` when `acc_wr`=1, and the two are never high together.
- R4: An access whose offset bit 6 is 1 uses an 11-cycle select with a strobe delay of 4, whatever the timing code.
- R5: An offset with bit 11 = 1 and bits 10..8 = k, where k < NUM_SEL, drives `ide_cs[k]` alone, one-hot, for the whole select window. `ide_da` carries offset bits 4..2 during the access.
- R6: An offset outside the existing windows (bit 11 = 0, or k >= NUM_SEL) runs the timing and gives the done pulse, but asserts no chip-select and no strobe.
- R7: A request is accepted when the sequencer is idle or in its done cycle. A request present during a select window is ignored.
- R8: The select starts in the cycle after acceptance. `acc_done` is high for exactly one cycle, the cycle right after the select falls.
- R9: The timing profile is fixed when a request is accepted. A speed-register write during an access affects only later accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spd_wr | input | 1 | Speed register write strobe |
| spd_wdata | input | 8 | Speed register write data |
| spd_rdata | output | 8 | Speed register read data |
| acc_req | input | 1 | Access request |
| acc_addr | input | 12 | Local offset of the access |
| acc_wr | input | 1 | 1 = write access, 0 = read access |
| ide_cs | output | NUM_SEL | Per-window chip-select, active high |
| ide_da | output | 3 | IDE register address (offset bits 4..2) |
| ide_rd | output | 1 | Read strobe, active high |
| ide_wr | output | 1 | Write strobe, active high |
| acc_done | output | 1 | One-cycle access completion pulse |

## Verification
The assertions assume that requests change only between clock edges, and that the requester either drops its request after acceptance or keeps it on purpose to queue a follow-on access at the done cycle. The stimulus drives every input on the falling edge. It raises a request only when the sequencer is idle, or holds it deliberately through a select window to test the hold-off rule. Speed writes are placed both between accesses and inside an access, so that the latching of the profile is seen at the ports.

// File: rtl/ide_seq_pkg.sv
package ide_seq_pkg;

  localparam int PROF_W = 4;

  typedef struct packed {
    logic [PROF_W-1:0] len;  // select cycles
    logic [PROF_W-1:0] dly;  // cycles before strobe
  } prof_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEL  = 2'd1,
    ST_DONE = 2'd2
  } seq_st_e;

  localparam prof_t SLOW_PROF = '{len: 4'd11, dly: 4'd4};

  function automatic prof_t code_prof(input logic [2:0] code);
    prof_t p;
    case (code)
      3'd0:    p = '{len: 4'd7,  dly: 4'd2};
      3'd1:    p = '{len: 4'd9,  dly: 4'd3};
      3'd2:    p = '{len: 4'd11, dly: 4'd4};
      3'd3:    p = '{len: 4'd5,  dly: 4'd1};
      3'd4:    p = '{len: 4'd5,  dly: 4'd2};
      3'd5:    p = '{len: 4'd5,  dly: 4'd3};
      3'd6:    p = '{len: 4'd15, dly: 4'd4};
      default: p = '{len: 4'd5,  dly: 4'd1};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/ide_speed_reg.sv
module ide_speed_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [2:0] code,
  output logic [7:0] rdata
);

  logic [2:0] code_q, code_nx;

  always_comb begin
    code_nx = code_q;
    if (wr_en) code_nx = wdata[7:5];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= 3'd0;
    else        code_q <= code_nx;
  end

  assign code  = code_q;
  assign rdata = {code_q, 5'b11111};

endmodule

// File: rtl/ide_win_decode.sv
module ide_win_decode #(
  parameter int NUM_SEL = 4
) (
  input  logic [11:0]        addr,
  output logic [NUM_SEL-1:0] hit,
  output logic               slow,
  output logic [2:0]         da
);

  logic unused_addr_bits;

  genvar g;
  generate
    for (g = 0; g < NUM_SEL; g++) begin : g_win
      assign hit[g] = addr[11] && (addr[10:8] == 3'(g));
    end
  endgenerate

  assign slow             = addr[6];
  assign da               = addr[4:2];
  assign unused_addr_bits = ^{addr[7], addr[5], addr[1:0]};

endmodule

// File: rtl/ide_strobe_fsm.sv
module ide_strobe_fsm
  import ide_seq_pkg::*;
#(
  parameter int NUM_SEL = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic               req_wr,
  input  logic [NUM_SEL-1:0] req_hit,
  input  logic [2:0]         req_da,
  input  prof_t              req_prof,
  output logic [NUM_SEL-1:0] cs,
  output logic [2:0]         da,
  output logic               strb_rd,
  output logic               strb_wr,
  output logic               done
);

  localparam int CNT_W = PROF_W;

  seq_st_e            st_q, st_nx;
  logic [CNT_W-1:0]   cnt_q, cnt_nx;
  prof_t              prof_q, prof_nx;
  logic [NUM_SEL-1:0] hit_q, hit_nx;
  logic               wr_q, wr_nx;
  logic [2:0]         da_q, da_nx;

  logic accept, last_cyc, in_sel, strb_on;

  assign accept   = req && (st_q != ST_SEL);
  assign last_cyc = (cnt_q == prof_q.len - CNT_W'(1));

  always_comb begin
    st_nx   = st_q;
    cnt_nx  = cnt_q;
    prof_nx = prof_q;
    hit_nx  = hit_q;
    wr_nx   = wr_q;
    da_nx   = da_q;
    case (st_q)
      ST_SEL: begin
        if (last_cyc) st_nx  = ST_DONE;
        else          cnt_nx = cnt_q + CNT_W'(1);
      end
      default: begin
        st_nx = ST_IDLE;
        if (accept) begin
          st_nx   = ST_SEL;
          cnt_nx  = '0;
          prof_nx = req_prof;
          hit_nx  = req_hit;
          wr_nx   = req_wr;
          da_nx   = req_da;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      prof_q <= '0;
      hit_q  <= '0;
      wr_q   <= 1'b0;
      da_q   <= 3'd0;
    end else begin
      st_q   <= st_nx;
      cnt_q  <= cnt_nx;
      prof_q <= prof_nx;
      hit_q  <= hit_nx;
      wr_q   <= wr_nx;
      da_q   <= da_nx;
    end
  end

  assign in_sel  = (st_q == ST_SEL);
  assign strb_on = in_sel && (|hit_q) && (cnt_q >= prof_q.dly);
  assign cs      = in_sel ? hit_q : '0;
  assign strb_rd = strb_on && !wr_q;
  assign strb_wr = strb_on && wr_q;
  assign done    = (st_q == ST_DONE);
  assign da      = da_q;

endmodule

// File: rtl/ide_strobe_seq.sv
module ide_strobe_seq
  import ide_seq_pkg::*;
#(
  parameter bit EXT_SEL = 1'b0,
  localparam int NUM_SEL = EXT_SEL ? 6 : 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               spd_wr,
  input  logic [7:0]         spd_wdata,
  output logic [7:0]         spd_rdata,
  input  logic               acc_req,
  input  logic [11:0]        acc_addr,
  input  logic               acc_wr,
  output logic [NUM_SEL-1:0] ide_cs,
  output logic [2:0]         ide_da,
  output logic               ide_rd,
  output logic               ide_wr,
  output logic               acc_done
);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic [2:0]         code;
  logic [NUM_SEL-1:0] hit;
  logic               slow;
  logic [2:0]         da_dec;
  prof_t              prof_sel;

  ide_speed_reg u_spd (
    .clk   (clk),
    .rst_n (rst_core_n),
    .wr_en (spd_wr),
    .wdata (spd_wdata),
    .code  (code),
    .rdata (spd_rdata)
  );

  ide_win_decode #(.NUM_SEL(NUM_SEL)) u_dec (
    .addr (acc_addr),
    .hit  (hit),
    .slow (slow),
    .da   (da_dec)
  );

  assign prof_sel = slow ? SLOW_PROF : code_prof(code);

  ide_strobe_fsm #(.NUM_SEL(NUM_SEL)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .req      (acc_req),
    .req_wr   (acc_wr),
    .req_hit  (hit),
    .req_da   (da_dec),
    .req_prof (prof_sel),
    .cs       (ide_cs),
    .da       (ide_da),
    .strb_rd  (ide_rd),
    .strb_wr  (ide_wr),
    .done     (acc_done)
  );

endmodule

// File: rtl/ide_seq_chk.sv
module ide_seq_chk #(
  parameter int NUM_SEL = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SEL-1:0] ide_cs,
  input logic               ide_rd,
  input logic               ide_wr,
  input logic               acc_done,
  input logic [7:0]         spd_rdata
);

  // R5
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ide_cs));

  // R5
  cs_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ide_cs) |=> ($stable(ide_cs) || !(|ide_cs)));

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ide_rd && ide_wr));

  // R3
  strobe_in_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ide_rd || ide_wr) |-> (|ide_cs));

  // R3
  strobe_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(|ide_cs) |-> $past(ide_rd || ide_wr));

  // R3
  strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ide_rd) || $fell(ide_wr)) |-> !(|ide_cs));

  // R8
  done_after_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(|ide_cs) |-> acc_done);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |=> !acc_done);

  // R1
  spd_low_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spd_rdata[4:0] == 5'b11111);

endmodule

bind ide_strobe_seq ide_seq_chk #(.NUM_SEL(NUM_SEL)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ide_cs    (ide_cs),
  .ide_rd    (ide_rd),
  .ide_wr    (ide_wr),
  .acc_done  (acc_done),
  .spd_rdata (spd_rdata)
);

// File: tb/tb_ide_strobe_seq.sv
module tb_ide_strobe_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        spd_wr;
  logic [7:0]  spd_wdata;
  logic [7:0]  spd_rdata;
  logic        acc_req;
  logic [11:0] acc_addr;
  logic        acc_wr;
  logic [3:0]  ide_cs;
  logic [2:0]  ide_da;
  logic        ide_rd, ide_wr, acc_done;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  ide_strobe_seq dut (
    .clk(clk), .rst_n(rst_n), .spd_wr(spd_wr), .spd_wdata(spd_wdata),
    .spd_rdata(spd_rdata), .acc_req(acc_req), .acc_addr(acc_addr),
    .acc_wr(acc_wr), .ide_cs(ide_cs), .ide_da(ide_da), .ide_rd(ide_rd),
    .ide_wr(ide_wr), .acc_done(acc_done)
  );

  typedef struct {
    logic [3:0] mask;
    int         len;
    int         dly;
    bit         wr;
    logic [2:0] da;
    string      tag;
  } exp_t;

  exp_t exp_q[$];

  int sel_tab[8] = '{7, 9, 11, 5, 5, 5, 15, 5};
  int dly_tab[8] = '{2, 3, 4, 1, 2, 3, 4, 1};

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic exp_t mk(input logic [11:0] a, input bit w, input int code, input string tag);
    exp_t e;
    int k;
    k = int'(a[10:8]);
    e.mask = (a[11] && k < 4) ? 4'(1 << k) : 4'b0;
    e.len  = a[6] ? 11 : sel_tab[code];
    e.dly  = a[6] ? 4 : dly_tab[code];
    e.wr   = w;
    e.da   = a[4:2];
    e.tag  = tag;
    return e;
  endfunction

  // monitor
  int         cs_cnt, st_at, st_cnt;
  logic [3:0] cs_seen;
  logic [2:0] da_seen;
  bit         saw_rd, saw_wr, prev_cs;

  initial begin
    cs_cnt = 0; st_at = 0; st_cnt = 0; cs_seen = '0; da_seen = '0;
    saw_rd = 0; saw_wr = 0; prev_cs = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (|ide_cs) begin
          cs_cnt++;
          cs_seen = ide_cs;
          da_seen = ide_da;
        end
        if (ide_rd || ide_wr) begin
          if (st_cnt == 0) st_at = cs_cnt - 1;
          st_cnt++;
          saw_rd |= ide_rd;
          saw_wr |= ide_wr;
        end
        if (acc_done) begin
          if (exp_q.size() == 0) begin
            chk(0, "R7 unexpected done", 1, 0);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(ide_cs == 4'b0, {e.tag, " R8 cs low at done"}, int'(ide_cs), 0);
            chk(cs_seen == e.mask, {e.tag, " R5/R6 cs mask"}, int'(cs_seen), int'(e.mask));
            if (e.mask != 0) begin
              chk(prev_cs, {e.tag, " R8 done follows select"}, int'(prev_cs), 1);
              chk(cs_cnt == e.len, {e.tag, " R2 select length"}, cs_cnt, e.len);
              chk(st_at == e.dly, {e.tag, " R2 strobe delay"}, st_at, e.dly);
              chk(st_at + st_cnt == cs_cnt, {e.tag, " R3 strobe ends with select"}, st_at + st_cnt, cs_cnt);
              chk(saw_wr == e.wr && saw_rd == !e.wr, {e.tag, " R3 strobe direction"}, int'(saw_wr), int'(e.wr));
              chk(da_seen == e.da, {e.tag, " R5 register address"}, int'(da_seen), int'(e.da));
            end else begin
              chk(st_cnt == 0, {e.tag, " R6 no strobe"}, st_cnt, 0);
            end
          end
          cs_cnt = 0; st_cnt = 0; st_at = 0; cs_seen = '0;
          saw_rd = 0; saw_wr = 0;
        end
        prev_cs = |ide_cs;
      end
    end
  end

  task automatic spd_write(input logic [7:0] d);
    @(negedge clk);
    spd_wr = 1'b1; spd_wdata = d;
    @(negedge clk);
    spd_wr = 1'b0;
  endtask

  task automatic wait_done;
    do @(negedge clk); while (!acc_done);
  endtask

  task automatic access(input logic [11:0] a, input bit w, input int code, input string tag);
    exp_q.push_back(mk(a, w, code, tag));
    @(negedge clk);
    acc_req = 1'b1; acc_addr = a; acc_wr = w;
    @(negedge clk);
    acc_req = 1'b0;
    wait_done();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; spd_wr = 1'b0; spd_wdata = '0;
    acc_req = 1'b0; acc_addr = '0; acc_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk(spd_rdata == 8'h1F, "R1 reset readback", int'(spd_rdata), 8'h1F);
    chk(ide_cs == 0 && !acc_done && !ide_rd && !ide_wr, "R8 idle outputs", int'(ide_cs), 0);

    // every timing code, each window and direction
    for (int c = 0; c < 8; c++) begin
      logic [11:0] a;
      spd_write({3'(c), 5'b01010});
      chk(spd_rdata == {3'(c), 5'b11111}, "R1 code readback", int'(spd_rdata), int'({3'(c), 5'b11111}));
      a = 12'h800 | 12'((c % 4) << 8) | 12'((c ^ 5) << 2);
      access(a, c[0], c, $sformatf("R2 code%0d", c));
    end

    // slow path overrides code 3
    spd_write(8'h60);
    access(12'h854, 1'b0, 3, "R4 slow read");
    access(12'hB4C, 1'b1, 3, "R4 slow write");

    // non-existent windows
    access(12'hC08, 1'b0, 3, "R6 window C");
    access(12'h404, 1'b1, 3, "R6 low offset");
    access(12'hF00, 1'b0, 3, "R6 window F");

    // code change during an access (R9)
    spd_write(8'h00);
    exp_q.push_back(mk(12'h904, 1'b0, 0, "R9 old code"));
    @(negedge clk);
    acc_req = 1'b1; acc_addr = 12'h904; acc_wr = 1'b0;
    @(negedge clk);
    acc_req = 1'b0;
    spd_wr = 1'b1; spd_wdata = 8'hC0;
    @(negedge clk);
    spd_wr = 1'b0;
    wait_done();
    access(12'hA10, 1'b1, 6, "R9 new code");

    // request held through a select window, second queued at done (R7)
    spd_write(8'h20);
    exp_q.push_back(mk(12'h808, 1'b1, 1, "R7 first"));
    exp_q.push_back(mk(12'h91C, 1'b0, 1, "R7 second"));
    @(negedge clk);
    acc_req = 1'b1; acc_addr = 12'h808; acc_wr = 1'b1;
    @(negedge clk);
    acc_addr = 12'h91C; acc_wr = 1'b0;
    wait_done();
    @(negedge clk);
    acc_req = 1'b0;
    chk(ide_cs == 4'b0010, "R8 select starts after acceptance", int'(ide_cs), 2);
    wait_done();
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R7 no extra access", exp_q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule